// File: doc/BRIEF.md
# Rheostat Command Decoder and Control Register

This block sits behind the serial front end of a digital rheostat. It takes one 16-bit command word per transfer, splits it into a command code and a data field, and keeps the wiper code, a small control register and a shutdown flag up to date. Updates to the wiper and to non-volatile storage are locked after reset. Software must unlock them through the control register.

Read commands prepare a 16-bit response word, which the front end shifts out during the following frame. Store, restore and memory-read commands become single-cycle requests to a separate non-volatile manager. The block waits for that manager's completion strobe before it takes the next word. A hardware restore input is queued even when the manager is busy. It clears shutdown and reloads the wiper.

Words arrive on a valid/ready stream. The front end holds `word_valid` and `word_data` steady until a cycle where `word_ready` is also high. `word_ready` drops while a manager operation is outstanding, while the manager reports busy, and while a hardware restore is pending. Nothing else causes back-pressure.

Top module: `rheo_cmd_ctrl`

## Requirements
- R1: After reset the wiper code is midscale (0x200), the control bits and the shutdown flag are 0, the response word is 0, and `word_ready` is 1.
- R2: Bits 13:10 of a word hold the command code and bits 9:0 hold the data field. Bits 15:14 are ignored. Codes 10 to 15 change nothing.
- R3: Code 1 loads the data field into the wiper code, but only while the write-enable bit C1 is 1. Otherwise the word has no effect on the wiper.
- R4: Code 7 sets C1 from data bit 1 and C0 from data bit 0. Code 8 loads the response word with C2 at bit 3, C1 at bit 1, C0 at bit 0 and zeros elsewhere.
- R5: Code 3 with store-enable C0 = 1 sends a store request (`nv_op` = 0) carrying the wiper code. Code 3 with C0 = 0 issues no request. When the store completes, C2 takes the value of `nv_ok`.
- R6: In the cycle after acceptance, code 2 loads the response with the zero-extended wiper code and code 6 loads it with `nv_last`. Code 5 issues a read request (`nv_op` = 2) with address = data bits 5:0, and the returned data is loaded into the response at completion. Non-read codes leave the response unchanged.
- R7: Code 4 or a pulse on `hw_restore` clears shutdown and issues a restore request (`nv_op` = 1). At completion the wiper takes `nv_rdata` whatever the value of C1.
- R8: Code 9 sets the shutdown flag to data bit 0. Every other command keeps working while the flag is set.
- R9: `word_ready` is 0 while a request is outstanding, while `nv_busy` is 1, or while a hardware restore waits. A word is taken only in a cycle where both valid and ready are high.
- R10: `nv_req` is a single-cycle pulse issued the cycle after the triggering event. `nv_op`, `nv_addr` and `nv_wdata` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Command word present |
| word_ready | output | 1 | Block can take a word |
| word_data | input | 16 | Command word |
| hw_restore | input | 1 | Hardware restore pulse |
| nv_busy | input | 1 | Manager cannot accept work |
| nv_done | input | 1 | Manager completion strobe |
| nv_ok | input | 1 | Store succeeded, valid with nv_done |
| nv_rdata | input | 10 | Restore or read data, valid with nv_done |
| nv_last | input | 6 | Last programmed memory address |
| nv_req | output | 1 | Request pulse to manager |
| nv_op | output | 2 | 0 store, 1 restore, 2 read |
| nv_addr | output | 6 | Read address |
| nv_wdata | output | 10 | Store data |
| wiper_code | output | 10 | Wiper position code |
| shutdown | output | 1 | Shutdown flag |
| resp_word | output | 16 | Response for the next frame |

## Verification
A word is accepted at a clock edge. Its effect on the wiper code, the control bits, the shutdown flag or a directly sourced response shows up right after that same edge. A request pulse appears one edge later. Manager-returned results, such as restored wiper codes, read data and C2, land at the edge that samples `nv_done`. A behavioural model in the bench follows these same edges. The bench drives inputs just after each rising edge and compares every output at the falling edge. Directed checks wait for the handshake and for the manager round trip before they sample.

// File: rtl/rheo_pkg.sv
package rheo_pkg;

  localparam int CMD_W = 4;

  typedef struct packed {
    logic wr_wiper;
    logic rd_wiper;
    logic store;
    logic restore;
    logic rd_mem;
    logic rd_last;
    logic wr_ctrl;
    logic rd_ctrl;
    logic set_shdn;
  } cmd_flags_t;

  typedef enum logic [1:0] {
    NV_STORE   = 2'd0,
    NV_RESTORE = 2'd1,
    NV_READ    = 2'd2
  } nv_op_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rheo_word_decode.sv
module rheo_word_decode
  import rheo_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  output cmd_flags_t        flags,
  output logic [CODE_W-1:0] data
);

  logic [CMD_W-1:0] code;

  assign code = word[CODE_W +: CMD_W];
  assign data = word[CODE_W-1:0];

  always_comb begin
    flags = '0;
    if (accept) begin
      case (code)
        4'd1:    flags.wr_wiper = 1'b1;
        4'd2:    flags.rd_wiper = 1'b1;
        4'd3:    flags.store    = 1'b1;
        4'd4:    flags.restore  = 1'b1;
        4'd5:    flags.rd_mem   = 1'b1;
        4'd6:    flags.rd_last  = 1'b1;
        4'd7:    flags.wr_ctrl  = 1'b1;
        4'd8:    flags.rd_ctrl  = 1'b1;
        4'd9:    flags.set_shdn = 1'b1;
        default: flags = '0;
      endcase
    end
  end

endmodule

// File: rtl/rheo_nv_seq.sv
module rheo_nv_seq
  import rheo_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_flags_t        flags,
  input  logic [CODE_W-1:0] data,
  input  logic [CODE_W-1:0] wiper,
  input  logic              store_en,
  input  logic              hw_restore,
  input  logic              nv_busy,
  input  logic              nv_done,
  output logic              take_ok,
  output logic              restore_start,
  output logic              done_fire,
  output nv_op_e            done_op,
  output logic              nv_req,
  output nv_op_e            nv_op,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [CODE_W-1:0] nv_wdata
);

  seq_state_e state;
  logic       hw_pend;
  logic       issue_hw;
  logic       start_store;
  logic       start_read;
  logic       start_any;

  assign issue_hw      = (state == SQ_IDLE) && !nv_busy && (hw_restore || hw_pend);
  assign take_ok       = (state == SQ_IDLE) && !nv_busy && !hw_pend && !hw_restore;
  assign start_store   = flags.store && store_en;
  assign start_read    = flags.rd_mem;
  assign restore_start = flags.restore || issue_hw;
  assign start_any     = start_store || start_read || restore_start;
  assign done_fire     = (state == SQ_WAIT) && nv_done;
  assign done_op       = nv_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      hw_pend  <= 1'b0;
      nv_req   <= 1'b0;
      nv_op    <= NV_STORE;
      nv_addr  <= '0;
      nv_wdata <= '0;
    end else begin
      nv_req  <= start_any;
      hw_pend <= issue_hw ? 1'b0 : (hw_pend || hw_restore);
      if (start_any) begin
        state    <= SQ_WAIT;
        nv_addr  <= data[ADDR_W-1:0];
        nv_wdata <= wiper;
        if (restore_start)    nv_op <= NV_RESTORE;
        else if (start_store) nv_op <= NV_STORE;
        else                  nv_op <= NV_READ;
      end else if (done_fire) begin
        state <= SQ_IDLE;
      end
    end
  end

endmodule

// File: rtl/rheo_ctrl_regs.sv
module rheo_ctrl_regs
  import rheo_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_flags_t        flags,
  input  logic [CODE_W-1:0] data,
  input  logic              restore_start,
  input  logic              restore_land,
  input  logic              store_land,
  input  logic              nv_ok,
  input  logic [CODE_W-1:0] nv_rdata,
  output logic [CODE_W-1:0] wiper,
  output logic              c0,
  output logic              c1,
  output logic              c2,
  output logic              shdn
);

  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper <= MID_CODE;
      c0    <= 1'b0;
      c1    <= 1'b0;
      c2    <= 1'b0;
      shdn  <= 1'b0;
    end else begin
      if (restore_land)
        wiper <= nv_rdata;
      else if (flags.wr_wiper && c1)
        wiper <= data;

      if (flags.wr_ctrl) begin
        c1 <= data[1];
        c0 <= data[0];
      end

      if (store_land)
        c2 <= nv_ok;

      if (restore_start)
        shdn <= 1'b0;
      else if (flags.set_shdn)
        shdn <= data[0];
    end
  end

endmodule

// File: rtl/rheo_resp_reg.sv
module rheo_resp_reg
  import rheo_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_flags_t        flags,
  input  logic [CODE_W-1:0] wiper,
  input  logic              c0,
  input  logic              c1,
  input  logic              c2,
  input  logic [ADDR_W-1:0] nv_last,
  input  logic              read_land,
  input  logic [CODE_W-1:0] nv_rdata,
  output logic [WORD_W-1:0] resp
);

  logic [WORD_W-1:0] ctrl_img;

  always_comb begin
    ctrl_img    = '0;
    ctrl_img[3] = c2;
    ctrl_img[1] = c1;
    ctrl_img[0] = c0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp <= '0;
    end else if (read_land) begin
      resp <= {{(WORD_W-CODE_W){1'b0}}, nv_rdata};
    end else if (flags.rd_wiper) begin
      resp <= {{(WORD_W-CODE_W){1'b0}}, wiper};
    end else if (flags.rd_last) begin
      resp <= {{(WORD_W-ADDR_W){1'b0}}, nv_last};
    end else if (flags.rd_ctrl) begin
      resp <= ctrl_img;
    end
  end

endmodule

// File: rtl/rheo_cmd_ctrl.sv
module rheo_cmd_ctrl
  import rheo_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 6,
  localparam int WORD_W = 2 + CMD_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              hw_restore,
  input  logic              nv_busy,
  input  logic              nv_done,
  input  logic              nv_ok,
  input  logic [CODE_W-1:0] nv_rdata,
  input  logic [ADDR_W-1:0] nv_last,
  output logic              nv_req,
  output logic [1:0]        nv_op,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [CODE_W-1:0] nv_wdata,
  output logic [CODE_W-1:0] wiper_code,
  output logic              shutdown,
  output logic [WORD_W-1:0] resp_word
);

  cmd_flags_t        flags;
  logic [CODE_W-1:0] data;
  logic              accept;
  logic              take_ok;
  logic              restore_start;
  logic              done_fire;
  nv_op_e            done_op;
  nv_op_e            op_q;
  logic              restore_land;
  logic              store_land;
  logic              read_land;
  logic              ctl_c0;
  logic              ctl_c1;
  logic              ctl_c2;

  assign word_ready   = take_ok;
  assign accept       = word_valid && take_ok;
  assign nv_op        = op_q;
  assign restore_land = done_fire && (done_op == NV_RESTORE);
  assign store_land   = done_fire && (done_op == NV_STORE);
  assign read_land    = done_fire && (done_op == NV_READ);

  rheo_word_decode #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_dec (
    .accept (accept),
    .word   (word_data),
    .flags  (flags),
    .data   (data)
  );

  rheo_nv_seq #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags         (flags),
    .data          (data),
    .wiper         (wiper_code),
    .store_en      (ctl_c0),
    .hw_restore    (hw_restore),
    .nv_busy       (nv_busy),
    .nv_done       (nv_done),
    .take_ok       (take_ok),
    .restore_start (restore_start),
    .done_fire     (done_fire),
    .done_op       (done_op),
    .nv_req        (nv_req),
    .nv_op         (op_q),
    .nv_addr       (nv_addr),
    .nv_wdata      (nv_wdata)
  );

  rheo_ctrl_regs #(.CODE_W(CODE_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags         (flags),
    .data          (data),
    .restore_start (restore_start),
    .restore_land  (restore_land),
    .store_land    (store_land),
    .nv_ok         (nv_ok),
    .nv_rdata      (nv_rdata),
    .wiper         (wiper_code),
    .c0            (ctl_c0),
    .c1            (ctl_c1),
    .c2            (ctl_c2),
    .shdn          (shutdown)
  );

  rheo_resp_reg #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .wiper     (wiper_code),
    .c0        (ctl_c0),
    .c1        (ctl_c1),
    .c2        (ctl_c2),
    .nv_last   (nv_last),
    .read_land (read_land),
    .nv_rdata  (nv_rdata),
    .resp      (resp_word)
  );

endmodule

// File: rtl/rheo_cmd_ctrl_chk.sv
module rheo_cmd_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_req,
  input logic [1:0]        nv_op,
  input logic              nv_busy,
  input logic              word_ready,
  input logic [CODE_W-1:0] wiper_code,
  input logic              shutdown,
  input logic              c0,
  input logic              c1,
  input logic              restore_land
);

  // R10: request is a single-cycle pulse
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |=> !nv_req);

  // R9: no word taken while the manager is busy
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !word_ready);

  // R9: no word taken while a request is outstanding
  p_req_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> !word_ready);

  // R3: wiper is frozen while write-enable is low, except for a restore landing
  p_wiper_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1 && !restore_land) |=> $stable(wiper_code));

  // R5: a store request only follows an enabled store
  p_store_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_op == 2'd0) |-> $past(c0));

  // R7: shutdown is off once a restore is requested
  p_restore_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_op == 2'd1) |-> !shutdown);

endmodule

bind rheo_cmd_ctrl rheo_cmd_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .nv_req       (nv_req),
  .nv_op        (nv_op),
  .nv_busy      (nv_busy),
  .word_ready   (word_ready),
  .wiper_code   (wiper_code),
  .shutdown     (shutdown),
  .c0           (ctl_c0),
  .c1           (ctl_c1),
  .restore_land (restore_land)
);

// File: tb/test_rheo_cmd_ctrl.sv
`timescale 1ns/1ps
module test_rheo_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        hw_restore = 1'b0;
  logic        nv_busy = 1'b0;
  logic        nv_done = 1'b0;
  logic        nv_ok = 1'b0;
  logic [9:0]  nv_rdata = '0;
  logic [5:0]  nv_last;
  logic        nv_req;
  logic [1:0]  nv_op;
  logic [5:0]  nv_addr;
  logic [9:0]  nv_wdata;
  logic [9:0]  wiper_code;
  logic        shutdown;
  logic [15:0] resp_word;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rheo_cmd_ctrl i_rheo_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .hw_restore(hw_restore), .nv_busy(nv_busy),
    .nv_done(nv_done), .nv_ok(nv_ok), .nv_rdata(nv_rdata), .nv_last(nv_last),
    .nv_req(nv_req), .nv_op(nv_op), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
    .wiper_code(wiper_code), .shutdown(shutdown), .resp_word(resp_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- manager model ----------------
  logic [9:0] mem [64];
  int last = 0;
  int cnt = 0;
  int lop, ladr, lwd;
  int seen_op = -1, seen_addr = -1, seen_wd = -1;
  assign nv_last = last[5:0];

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; nv_done = 0; last = 0;
    end else begin
      nv_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          nv_done = 1;
          if (lop == 0) begin
            if (last < 50) begin last++; mem[last] = lwd[9:0]; nv_ok = 1; end
            else nv_ok = 0;
          end else if (lop == 1) nv_rdata = (last == 0) ? 10'h200 : mem[last];
          else nv_rdata = mem[ladr];
        end
      end else if (nv_req) begin
        cnt = 3; lop = nv_op; ladr = nv_addr; lwd = nv_wdata;
        seen_op = nv_op; seen_addr = nv_addr; seen_wd = nv_wdata;
      end
    end
  end

  // ---------------- reference model ----------------
  int m_wiper = 'h200, m_c0 = 0, m_c1 = 0, m_c2 = 0, m_shdn = 0, m_resp = 0;
  int m_wait = 0, m_op = 0, m_hwpend = 0, m_req = 0;
  int m_addr = 0, m_wd = 0;

  always @(posedge clk) begin
    int cmd, d, issue_hw, acc;
    if (!rst_n) begin
      m_wiper = 'h200; m_c0 = 0; m_c1 = 0; m_c2 = 0; m_shdn = 0; m_resp = 0;
      m_wait = 0; m_hwpend = 0; m_req = 0;
    end else begin
      issue_hw = !m_wait && !nv_busy && (hw_restore || m_hwpend);
      acc = word_valid && !m_wait && !nv_busy && !m_hwpend && !hw_restore;
      cmd = word_data[13:10];
      d = word_data[9:0];
      m_req = 0;
      if (m_wait && nv_done) begin
        if (m_op == 0) m_c2 = nv_ok;
        else if (m_op == 1) m_wiper = nv_rdata;
        else m_resp = nv_rdata;
        m_wait = 0;
      end
      if (issue_hw) begin
        m_shdn = 0; m_req = 1; m_op = 1; m_wait = 1; m_hwpend = 0;
      end else if (hw_restore) m_hwpend = 1;
      if (acc) begin
        case (cmd)
          1: if (m_c1) m_wiper = d;
          2: m_resp = m_wiper;
          3: if (m_c0) begin m_req = 1; m_op = 0; m_wd = m_wiper; m_wait = 1; end
          4: begin m_shdn = 0; m_req = 1; m_op = 1; m_wait = 1; end
          5: begin m_req = 1; m_op = 2; m_addr = d % 64; m_wait = 1; end
          6: m_resp = last;
          7: begin m_c1 = (d >> 1) & 1; m_c0 = d & 1; end
          8: m_resp = m_c2 * 8 + m_c1 * 2 + m_c0;
          9: m_shdn = d & 1;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 word_ready", word_ready,
          (!m_wait && !nv_busy && !m_hwpend && !hw_restore) ? 1 : 0);
      chk("R3 wiper_code", wiper_code, m_wiper);
      chk("R8 shutdown", shutdown, m_shdn);
      chk("R6 resp_word", resp_word, m_resp);
      chk("R10 nv_req", nv_req, m_req);
      if (nv_req && m_req) begin
        chk("R10 nv_op", nv_op, m_op);
        if (m_op == 2) chk("R6 nv_addr", nv_addr, m_addr);
        if (m_op == 0) chk("R5 nv_wdata", nv_wdata, m_wd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [15:0] w);
    logic r;
    @(posedge clk); #1;
    word_valid = 1'b1; word_data = w;
    forever begin
      @(negedge clk); r = word_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 word_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wiper", wiper_code, 'h200);
    chk("R1 shutdown", shutdown, 0);
    chk("R1 resp", resp_word, 0);
    chk("R1 ready", word_ready, 1);

    send(16'h0555); settle();
    chk("R3 locked write ignored", wiper_code, 'h200);
    send(16'h2000); settle();
    chk("R4 ctrl readback default", resp_word, 0);
    send(16'h1C03); send(16'h2000); settle();
    chk("R4 ctrl readback", resp_word, 'h0003);
    send(16'h0555); settle();
    chk("R3 wiper write", wiper_code, 'h155);
    send(16'h0800); settle();
    chk("R6 wiper readback", resp_word, 'h155);
    send(16'hC4AA); settle();
    chk("R2 top bits ignored", wiper_code, 'h0AA);
    send(16'h2BFF); settle();
    chk("R2 code 10 wiper", wiper_code, 'h0AA);
    chk("R2 code 10 resp", resp_word, 'h155);

    send(16'h0C00); settle();
    chk("R5 store op", seen_op, 0);
    chk("R5 store data", seen_wd, 'h0AA);
    send(16'h2000); settle();
    chk("R5 success bit", resp_word, 'h000B);
    send(16'h1800); settle();
    chk("R6 last address", resp_word, 1);
    send(16'h1401); settle();
    chk("R6 read op", seen_op, 2);
    chk("R6 read addr", seen_addr, 1);
    chk("R6 memory readback", resp_word, 'h0AA);

    send(16'h2401); settle();
    chk("R8 shutdown set", shutdown, 1);
    send(16'h07FF); settle();
    chk("R8 write in shutdown", wiper_code, 'h3FF);
    chk("R8 still shut", shutdown, 1);
    send(16'h1000); @(negedge clk);
    chk("R7 restore wakes", shutdown, 0);
    settle();
    chk("R7 restore op", seen_op, 1);
    chk("R7 restored wiper", wiper_code, 'h0AA);

    send(16'h1C00);
    seen_op = -1;
    send(16'h0C00); settle();
    chk("R5 store gated", seen_op, -1);
    send(16'h1800); settle();
    chk("R5 no new location", resp_word, 1);
    send(16'h0555); settle();
    chk("R3 relocked", wiper_code, 'h0AA);
    send(16'h1C02); send(16'h0500); settle();
    chk("R3 write after unlock", wiper_code, 'h100);
    send(16'h2401); settle();

    // hardware restore held off by busy
    @(posedge clk); #1 nv_busy = 1'b1; hw_restore = 1'b1;
    @(posedge clk); #1 hw_restore = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 pending restore blocks", word_ready, 0);
    chk("R7 wiper before restore", wiper_code, 'h100);
    @(posedge clk); #1 nv_busy = 1'b0;
    settle();
    chk("R7 hw restore wakes", shutdown, 0);
    chk("R7 hw restore wiper", wiper_code, 'h0AA);

    // word held during busy
    @(posedge clk); #1 nv_busy = 1'b1; word_valid = 1'b1; word_data = 16'h0533;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 busy holds word", wiper_code, 'h0AA);
    chk("R9 busy ready", word_ready, 0);
    @(posedge clk); #1 nv_busy = 1'b0;
    @(posedge clk); #1 word_valid = 1'b0;
    settle();
    chk("R9 accepted after busy", wiper_code, 'h133);

    finish_run();
  end

endmodule